// File: doc/BRIEF.md
# Serial Flash Identification Prober

This block asks a serial flash device for its identity and decides whether it is the device software expects. After a start pulse it hands the one-byte read-identification opcode to a byte-level serial engine, together with the number of response bytes to collect (three or four). It then takes those bytes back from the engine, builds a manufacturer ID and a device ID from them, and compares both with expected values that the host supplies with the start pulse.

Vendors whose JEDEC bank code needs a continuation prefix answer with 0x7F first. In that case the manufacturer ID spans two bytes and the device ID takes the bytes after them. The prober checks odd parity on the vendor bytes and raises a warning without abandoning the probe. An expected device ID equal to a reserved generic value turns the compare into a manufacturer-only match. The serial engine can report a transfer error, which ends the probe at once with an error flag and no match.

Both byte streams use valid/ready. The opcode byte on the transmit side stays valid, with data and length unchanged, until the engine accepts it. The engine is free to hold ready low for any number of cycles. On the receive side the prober asserts ready only while it is still owed response bytes. A byte counts as delivered in a cycle where valid and ready are both high. The engine may hold valid low between bytes for any number of cycles.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, done, busy, tx_valid, rx_ready, err, both match flags, both parity warnings and both ID outputs are all 0.
- R2: A start pulse while idle makes tx_valid high in the next cycle, with tx_data = 0x9F and tx_rlen = 4 when four_byte = 1 or 3 when four_byte = 0. These hold unchanged while tx_ready is low, and rx_ready stays low until the opcode is accepted.
- R3: Once the opcode is accepted, rx_ready rises in the next cycle. The block takes exactly tx_rlen bytes, numbered byte0 first, and drops rx_ready in the cycle after the last one.
- R4: When byte0 is not 0x7F, mfr_id = {0x00, byte0} and dev_id = {byte1, byte2}. A fourth byte, if read, does not affect either ID.
- R5: When byte0 is 0x7F, mfr_id = {byte0, byte1}. dev_id = {0x00, byte2} in three-byte mode and {byte2, byte3} in four-byte mode.
- R6: par_warn0 is 1 when byte0 has an even number of one bits. par_warn1 is 1 when byte0 is 0x7F and byte1 has an even number of one bits. Either warning still lets the probe finish with normal ID and match results.
- R7: exact_hit is 1 when mfr_id equals exp_mfr and dev_id equals exp_dev.
- R8: vendor_hit is 1 when mfr_id equals exp_mfr, exp_dev equals the generic value (0xFFFF by default) and exact_hit is 0. The two hit flags are never both 1.
- R9: done is high for exactly one cycle, in the same cycle the results first show. The results stay unchanged until the next done.
- R10: spi_err high during the opcode or receive phase gives done in the next cycle with err = 1, both hits 0, both warnings 0 and both IDs 0. The next probe that completes clears err.
- R11: start while busy is ignored. No new opcode is presented, and the results use the expected IDs and mode captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (taken only while idle) |
| four_byte | input | 1 | 1: read four response bytes, 0: three |
| exp_mfr | input | 16 | Expected manufacturer ID |
| exp_dev | input | 16 | Expected device ID (generic value = vendor-only compare) |
| tx_valid | output | 1 | Opcode byte offered to the serial engine |
| tx_ready | input | 1 | Engine accepts the opcode byte |
| tx_data | output | 8 | Opcode byte |
| tx_rlen | output | 3 | Number of response bytes the engine must return |
| rx_valid | input | 1 | Engine offers a response byte |
| rx_ready | output | 1 | Prober takes a response byte |
| rx_data | input | 8 | Response byte |
| spi_err | input | 1 | Engine transfer error, aborts the probe |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Last probe aborted by engine error |
| exact_hit | output | 1 | Both IDs equal the expected values |
| vendor_hit | output | 1 | Manufacturer equal, generic device expected |
| par_warn0 | output | 1 | Parity violation on byte0 |
| par_warn1 | output | 1 | Parity violation on byte1 (continuation form) |
| mfr_id | output | 16 | Assembled manufacturer ID |
| dev_id | output | 16 | Assembled device ID |

## Verification
A corrupted byte counter shows up at rx_ready in the cycle after the last expected byte: the prober either keeps accepting bytes or stops one byte early. A wrong capture slot or a wrong continuation decision shows in mfr_id and dev_id in the cycle where done rises. A controller that loses its phase shows as a second opcode offer, or as tx_valid and rx_ready both high, within one cycle. The bench therefore checks the handshake pins cycle by cycle and compares the IDs and flags against values worked out from the injected bytes.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPC  = 2'd1,
    PH_RECV = 2'd2,
    PH_EVAL = 2'd3
  } probe_phase_e;
endpackage

// File: rtl/flash_id_seq.sv
module flash_id_seq
  import flash_id_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             four_byte,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic             spi_err,
  output logic             launch,
  output logic             mode4,
  output logic             tx_valid,
  output logic             rx_ready,
  output logic             cap_en,
  output logic [CNT_W-1:0] idx,
  output logic [CNT_W-1:0] rlen,
  output logic             fin_ok,
  output logic             fin_err,
  output logic             busy
);
  localparam logic [CNT_W-1:0] LAST4 = CNT_W'(NBYTES - 1);
  localparam logic [CNT_W-1:0] LAST3 = CNT_W'(NBYTES - 2);

  probe_phase_e ph;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = mode4 ? LAST4 : LAST3;
  assign rlen     = mode4 ? CNT_W'(NBYTES) : CNT_W'(NBYTES - 1);
  assign launch   = (ph == PH_IDLE) && start;
  assign tx_valid = (ph == PH_OPC);
  assign rx_ready = (ph == PH_RECV);
  assign cap_en   = rx_ready && rx_valid && !spi_err;
  assign fin_ok   = (ph == PH_EVAL);
  assign fin_err  = ((ph == PH_OPC) || (ph == PH_RECV)) && spi_err;
  assign busy     = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      idx   <= '0;
      mode4 <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          mode4 <= four_byte;
          ph    <= PH_OPC;
        end
        PH_OPC: begin
          if (spi_err)       ph <= PH_IDLE;
          else if (tx_ready) begin
            ph  <= PH_RECV;
            idx <= '0;
          end
        end
        PH_RECV: begin
          if (spi_err) ph <= PH_IDLE;
          else if (rx_valid) begin
            idx <= idx + 1'b1;
            if (idx == last_idx) ph <= PH_EVAL;
          end
        end
        PH_EVAL: ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_id_capture.sv
module flash_id_capture #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4,
  parameter int CNT_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cap_en,
  input  logic [CNT_W-1:0]               idx,
  input  logic [BYTE_W-1:0]              rx_data,
  output logic [NBYTES-1:0][BYTE_W-1:0]  resp
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              resp[g] <= '0;
      else if (cap_en && idx == CNT_W'(g))     resp[g] <= rx_data;
    end
  end
endmodule

// File: rtl/flash_id_decode.sv
module flash_id_decode #(
  parameter int                  BYTE_W      = 8,
  parameter int                  NBYTES      = 4,
  parameter logic [BYTE_W-1:0]   CONT_CODE   = 8'h7F,
  parameter logic [2*BYTE_W-1:0] GENERIC_DEV = 16'hFFFF
) (
  input  logic [NBYTES-1:0][BYTE_W-1:0] resp,
  input  logic                          mode4,
  input  logic [2*BYTE_W-1:0]           want_mfr,
  input  logic [2*BYTE_W-1:0]           want_dev,
  output logic [2*BYTE_W-1:0]           mfr,
  output logic [2*BYTE_W-1:0]           dev,
  output logic                          pw0,
  output logic                          pw1,
  output logic                          exact,
  output logic                          vendor
);
  logic cont, mfr_eq;

  always_comb begin
    cont = (resp[0] == CONT_CODE);
    if (cont) begin
      mfr = {resp[0], resp[1]};
      dev = mode4 ? {resp[2], resp[3]} : {{BYTE_W{1'b0}}, resp[2]};
    end else begin
      mfr = {{BYTE_W{1'b0}}, resp[0]};
      dev = {resp[1], resp[2]};
    end
    pw0    = ~(^resp[0]);
    pw1    = cont & ~(^resp[1]);
    mfr_eq = (mfr == want_mfr);
    exact  = mfr_eq && (dev == want_dev);
    vendor = mfr_eq && (want_dev == GENERIC_DEV) && !exact;
  end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int                  BYTE_W      = 8,
  parameter logic [BYTE_W-1:0]   OPCODE      = 8'h9F,
  parameter logic [BYTE_W-1:0]   CONT_CODE   = 8'h7F,
  parameter logic [2*BYTE_W-1:0] GENERIC_DEV = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              four_byte,
  input  logic [15:0]       exp_mfr,
  input  logic [15:0]       exp_dev,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic [2:0]        tx_rlen,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              spi_err,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              exact_hit,
  output logic              vendor_hit,
  output logic              par_warn0,
  output logic              par_warn1,
  output logic [15:0]       mfr_id,
  output logic [15:0]       dev_id
);
  localparam int ID_W   = 2 * BYTE_W;
  localparam int NBYTES = 4;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  logic                         launch, mode4, cap_en, fin_ok, fin_err;
  logic [CNT_W-1:0]             idx, rlen;
  logic [NBYTES-1:0][BYTE_W-1:0] resp;
  logic [ID_W-1:0]              want_mfr, want_dev, d_mfr, d_dev;
  logic                         d_pw0, d_pw1, d_exact, d_vendor;

  flash_id_seq #(.NBYTES(NBYTES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .four_byte(four_byte),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .spi_err(spi_err),
    .launch(launch), .mode4(mode4), .tx_valid(tx_valid), .rx_ready(rx_ready),
    .cap_en(cap_en), .idx(idx), .rlen(rlen), .fin_ok(fin_ok),
    .fin_err(fin_err), .busy(busy)
  );

  flash_id_capture #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .idx(idx),
    .rx_data(rx_data), .resp(resp)
  );

  flash_id_decode #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .CONT_CODE(CONT_CODE),
                    .GENERIC_DEV(GENERIC_DEV)) u_dec (
    .resp(resp), .mode4(mode4), .want_mfr(want_mfr), .want_dev(want_dev),
    .mfr(d_mfr), .dev(d_dev), .pw0(d_pw0), .pw1(d_pw1),
    .exact(d_exact), .vendor(d_vendor)
  );

  assign tx_data = OPCODE;
  assign tx_rlen = rlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_mfr <= '0;
      want_dev <= '0;
    end else if (launch) begin
      want_mfr <= exp_mfr;
      want_dev <= exp_dev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      err        <= 1'b0;
      exact_hit  <= 1'b0;
      vendor_hit <= 1'b0;
      par_warn0  <= 1'b0;
      par_warn1  <= 1'b0;
      mfr_id     <= '0;
      dev_id     <= '0;
    end else begin
      done <= fin_ok | fin_err;
      if (fin_err) begin
        err        <= 1'b1;
        exact_hit  <= 1'b0;
        vendor_hit <= 1'b0;
        par_warn0  <= 1'b0;
        par_warn1  <= 1'b0;
        mfr_id     <= '0;
        dev_id     <= '0;
      end else if (fin_ok) begin
        err        <= 1'b0;
        exact_hit  <= d_exact;
        vendor_hit <= d_vendor;
        par_warn0  <= d_pw0;
        par_warn1  <= d_pw1;
        mfr_id     <= d_mfr;
        dev_id     <= d_dev;
      end
    end
  end
endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic [2:0]  tx_rlen,
  input logic        rx_ready,
  input logic        spi_err,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        exact_hit,
  input logic        vendor_hit,
  input logic        par_warn0,
  input logic        par_warn1,
  input logic [15:0] mfr_id,
  input logic [15:0] dev_id
);
  assert_opcode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !spi_err) |=> (tx_valid && $stable(tx_data) && $stable(tx_rlen)));

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  assert_hit_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(exact_hit && vendor_hit));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({err, exact_hit, vendor_hit, par_warn0, par_warn1, mfr_id, dev_id}));

  assert_err_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (!exact_hit && !vendor_hit && !par_warn0 && !par_warn1 && mfr_id == 16'h0 && dev_id == 16'h0));

  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_valid && start) |=> !tx_valid);
endmodule

bind flash_id_probe flash_id_probe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_rlen(tx_rlen),
  .rx_ready(rx_ready), .spi_err(spi_err), .busy(busy), .done(done),
  .err(err), .exact_hit(exact_hit), .vendor_hit(vendor_hit),
  .par_warn0(par_warn0), .par_warn1(par_warn1), .mfr_id(mfr_id),
  .dev_id(dev_id)
);

// File: tb/sim_flash_id_probe.sv
`timescale 1ns/1ps
module sim_flash_id_probe;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, four_byte = 0, tx_ready = 0, rx_valid = 0, spi_err = 0;
  logic [15:0] exp_mfr = 0, exp_dev = 0;
  logic [7:0] rx_data = 0;
  logic tx_valid, rx_ready, busy, done, err, exact_hit, vendor_hit, par_warn0, par_warn1;
  logic [7:0] tx_data;
  logic [2:0] tx_rlen;
  logic [15:0] mfr_id, dev_id;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_id_probe u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic probe(input string tag, input logic [7:0] b0, b1, b2, b3,
                       input logic four, input logic [15:0] em, ed,
                       input int stall, input int errat, input bit poke);
    logic [7:0] bs [4];
    int n, w;
    bit aborted;
    logic [15:0] m, d;
    logic ex, vn, w0, w1;
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    n = four ? 4 : 3;
    if (b0 == 8'h7F) begin
      m = {b0, b1};
      d = four ? {b2, b3} : {8'h00, b2};
    end else begin
      m = {8'h00, b0};
      d = {b1, b2};
    end
    ex = (m == em) && (d == ed);
    vn = (m == em) && (ed == 16'hFFFF) && !ex;
    w0 = ~(^b0);
    w1 = (b0 == 8'h7F) && ~(^b1);

    @(negedge clk); start = 1; four_byte = four; exp_mfr = em; exp_dev = ed;
    @(negedge clk); start = 0;
    chk(tx_valid && tx_data == 8'h9F && !rx_ready, {tag, " R2 opcode"}, {tx_valid, tx_data}, {1'b1, 8'h9F});
    chk(tx_rlen == 3'(n), {tag, " R2 rlen"}, tx_rlen, n);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == 8'h9F && tx_rlen == 3'(n) && !rx_ready, {tag, " R2 hold"}, {tx_valid, tx_data}, {1'b1, 8'h9F});
    end
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk(rx_ready && !tx_valid, {tag, " R3 rx phase"}, {rx_ready, tx_valid}, 2'b10);
    if (poke) begin
      start = 1; exp_mfr = ~em; exp_dev = ~ed; four_byte = ~four;
      @(negedge clk); start = 0;
      chk(!tx_valid && rx_ready, {tag, " R11 start ignored"}, tx_valid, 0);
    end
    aborted = 0;
    for (int i = 0; i < n; i++) begin
      if (i == errat) begin
        spi_err = 1;
        @(negedge clk); spi_err = 0;
        aborted = 1;
        break;
      end
      rx_valid = 1; rx_data = bs[i];
      @(negedge clk); rx_valid = 0;
    end
    if (aborted) begin
      chk(done && err && !exact_hit && !vendor_hit && !par_warn0 && !par_warn1 && mfr_id == 0 && dev_id == 0,
          {tag, " R10 abort"}, {done, err, exact_hit, vendor_hit, mfr_id}, {4'b1100, 16'h0});
    end else begin
      chk(!rx_ready, {tag, " R3 byte count"}, rx_ready, 0);
      w = 0;
      while (!done && w < 8) begin @(negedge clk); w++; end
      chk(done && w == 1, {tag, " R9 done timing"}, w, 1);
      chk(mfr_id == m, {tag, " R4/R5 mfr"}, mfr_id, m);
      chk(dev_id == d, {tag, " R4/R5 dev"}, dev_id, d);
      chk(exact_hit == ex, {tag, " R7 exact"}, exact_hit, ex);
      chk(vendor_hit == vn, {tag, " R8 vendor"}, vendor_hit, vn);
      chk(par_warn0 == w0 && par_warn1 == w1, {tag, " R6 parity"}, {par_warn0, par_warn1}, {w0, w1});
      chk(!err, {tag, " R10 err clear"}, err, 0);
    end
    @(negedge clk);
    chk(!done, {tag, " R9 pulse"}, done, 0);
    repeat (3) @(negedge clk);
    chk(aborted ? (mfr_id == 0) : (mfr_id == m && dev_id == d), {tag, " R9 stable"}, mfr_id, aborted ? 16'h0 : m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !busy && !tx_valid && !rx_ready && !err && !exact_hit && !vendor_hit &&
        !par_warn0 && !par_warn1 && mfr_id == 0 && dev_id == 0, "R1 reset", {done, busy, tx_valid, mfr_id}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !tx_valid, "R1 idle after reset", {busy, tx_valid}, 0);

    probe("plain3",   8'hEF, 8'h40, 8'h18, 8'h00, 0, 16'h00EF, 16'h4018, 0, -1, 0);
    probe("plain4",   8'hEF, 8'h40, 8'h18, 8'h55, 1, 16'h00EF, 16'h4018, 2, -1, 0);
    probe("cont4",    8'h7F, 8'h9D, 8'h20, 8'h16, 1, 16'h7F9D, 16'h2016, 0, -1, 0);
    probe("cont3",    8'h7F, 8'h9D, 8'h20, 8'h16, 0, 16'h7F9D, 16'h0020, 3, -1, 0);
    probe("vendor",   8'hC2, 8'h20, 8'h15, 8'h00, 0, 16'h00C2, 16'hFFFF, 0, -1, 0);
    probe("miss",     8'hC2, 8'h20, 8'h15, 8'h00, 0, 16'h00EF, 16'hFFFF, 0, -1, 0);
    probe("miss_dev", 8'hC2, 8'h20, 8'h15, 8'h00, 0, 16'h00C2, 16'h2016, 0, -1, 0);
    probe("par0",     8'h03, 8'h11, 8'h22, 8'h00, 0, 16'h0003, 16'h1122, 0, -1, 0);
    probe("par1",     8'h7F, 8'h03, 8'h44, 8'h00, 0, 16'h7F03, 16'h0044, 0, -1, 0);
    probe("abort",    8'hEF, 8'h40, 8'h18, 8'h00, 0, 16'h00EF, 16'h4018, 0, 1, 0);
    probe("recover",  8'hEF, 8'h40, 8'h18, 8'h00, 0, 16'h00EF, 16'h4018, 0, -1, 0);
    probe("busy",     8'h7F, 8'h9D, 8'h20, 8'h16, 1, 16'h7F9D, 16'h2016, 1, -1, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule